// File: doc/BRIEF.md
# Cascadable Dual Timer Pair

This block holds two 8-bit up-counters, a low timer and a high timer, each compared against its own compare value. A 2-bit mode input sets how the two cooperate. In the split modes each timer counts its own ticks and, when a step would bring it onto its compare value, it clears to zero and pulses its interrupt. The high timer then takes its ticks either from the low timer's matches (a cascade) or from a separate external tick, depending on a 2-bit source select. In the joined mode the pair acts as one 16-bit counter that only the low tick advances. The low byte's wrap to zero carries into the high byte, and the match needs both bytes to reach their compare values at once.

A timer advances only on a cycle where its tick is high, its own run input is high and the shared prescaler enable is high. The interrupt outputs are one-cycle pulses. Each pulse is registered on the same clock edge that clears the matching counter. The counter values are visible at the ports at all times.

Top module: `tmr_pair`

## Requirements
- R1: While rst_n is low, both counters read 0 and both interrupt outputs read 0.
- R2: A counter holds its value on any cycle where its tick, its run input or pre_en is low.
- R3: In split mode (mode 0), a low step whose incremented count equals cmp_lo clears cnt_lo to 0. On that same edge irq_lo goes high for one cycle.
- R4: In split mode with hi_src equal to 0, the high timer advances once per low-timer match and ignores tick_hi_ext. When its incremented count equals cmp_hi it clears and pulses irq_hi.
- R5: In split mode with hi_src nonzero, the high timer advances on tick_hi_ext and not on low-timer matches.
- R6: In joined mode (mode 1), only tick_lo gated by run_lo and pre_en advances the pair. When cnt_lo wraps from 255 to 0, cnt_hi increments. tick_hi_ext has no effect.
- R7: In joined mode, a match occurs only when the incremented low byte equals cmp_lo and the resulting high byte equals cmp_hi. A low-byte match alone does nothing. On a full match both bytes clear to 0, and irq_lo and irq_hi pulse together.
- R8: Modes 2 and 3 count and match exactly as mode 0, with no other output.
- R9: With a compare value of 0 in split mode, a timer matches when its count wraps from 255, which takes 256 steps.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_lo | input | 1 | Prescaled count tick for the low timer |
| tick_hi_ext | input | 1 | External prescaled tick for the high timer |
| run_lo | input | 1 | Low timer run enable |
| run_hi | input | 1 | High timer run enable |
| pre_en | input | 1 | Shared prescaler enable |
| mode | input | 2 | 0 split, 1 joined 16-bit, 2 and 3 treated as split |
| hi_src | input | 2 | High timer clock source: 0 low-timer match, nonzero external tick |
| cmp_lo | input | 8 | Low timer compare value |
| cmp_hi | input | 8 | High timer compare value |
| irq_lo | output | 1 | Low timer match pulse |
| irq_hi | output | 1 | High timer match pulse |
| cnt_lo | output | 8 | Low counter value |
| cnt_hi | output | 8 | High counter value |

## Verification
Each gating input is dropped in turn while ticks arrive, which shows that every input of the enable is needed. In the cascade runs tick_hi_ext is held high throughout, so a high count that follows the low matches shows that the high timer takes its clock from the match and not from the external tick. The external-source run does the reverse. The joined-mode run first brings the low byte onto its compare value while the high byte is off. It then crosses the 255-to-0 carry and ends on the full match, which separates a match on one byte from a match on both. The wrap run with a compare value of 0 and the runs in modes 2 and 3 cover the remaining corner cases of matching.

// File: rtl/tmr_pair.sv
module tmr_pair #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_lo,
  input  logic         tick_hi_ext,
  input  logic         run_lo,
  input  logic         run_hi,
  input  logic         pre_en,
  input  logic [1:0]   mode,
  input  logic [1:0]   hi_src,
  input  logic [W-1:0] cmp_lo,
  input  logic [W-1:0] cmp_hi,
  output logic         irq_lo,
  output logic         irq_hi,
  output logic [W-1:0] cnt_lo,
  output logic [W-1:0] cnt_hi
);
  localparam logic [1:0] MODE_WIDE = 2'd1;

  logic         wide, lo_on, hi_on, hi_clk, carry;
  logic         m16, m8lo, m8hi;
  logic [W-1:0] lo_nx, hi_nx, hi_nx_w;

  assign wide    = (mode == MODE_WIDE);
  assign lo_on   = pre_en & run_lo & tick_lo;
  assign lo_nx   = cnt_lo + 1'b1;
  assign carry   = (lo_nx == '0);
  assign hi_nx_w = cnt_hi + W'(carry);
  assign m16     = wide & lo_on & (lo_nx == cmp_lo) & (hi_nx_w == cmp_hi);
  assign m8lo    = !wide & lo_on & (lo_nx == cmp_lo);
  assign hi_clk  = (hi_src == 2'd0) ? m8lo : tick_hi_ext;
  assign hi_on   = !wide & pre_en & run_hi & hi_clk;
  assign hi_nx   = cnt_hi + 1'b1;
  assign m8hi    = hi_on & (hi_nx == cmp_hi);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_lo <= '0;
      cnt_hi <= '0;
      irq_lo <= 1'b0;
      irq_hi <= 1'b0;
    end else begin
      irq_lo <= m16 | m8lo;
      irq_hi <= m16 | m8hi;
      if (wide) begin
        if (lo_on) begin
          cnt_lo <= m16 ? '0 : lo_nx;
          cnt_hi <= m16 ? '0 : hi_nx_w;
        end
      end else begin
        if (lo_on) cnt_lo <= m8lo ? '0 : lo_nx;
        if (hi_on) cnt_hi <= m8hi ? '0 : hi_nx;
      end
    end
  end
endmodule

// File: rtl/tmr_pair_chk.sv
module tmr_pair_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         tick_lo,
  input logic         pre_en,
  input logic [1:0]   mode,
  input logic [1:0]   hi_src,
  input logic         irq_lo,
  input logic         irq_hi,
  input logic [W-1:0] cnt_lo,
  input logic [W-1:0] cnt_hi
);
  assert_irq_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    irq_lo |-> (cnt_lo == '0));

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !pre_en |=> ($stable(cnt_lo) && $stable(cnt_hi) && !irq_lo && !irq_hi));

  assert_cascade_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_hi && $past(mode) != 2'd1 && $past(hi_src) == 2'd0) |-> irq_lo);

  assert_wide_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd1 && !tick_lo) |=> ($stable(cnt_hi) && $stable(cnt_lo)));

  assert_pair_irq_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_lo && $past(mode) == 2'd1) |-> irq_hi);
endmodule

bind tmr_pair tmr_pair_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick_lo(tick_lo), .pre_en(pre_en),
  .mode(mode), .hi_src(hi_src), .irq_lo(irq_lo), .irq_hi(irq_hi),
  .cnt_lo(cnt_lo), .cnt_hi(cnt_hi)
);

// File: tb/tmr_pair_tb.sv
module tmr_pair_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_lo = 0, tick_hi_ext = 0, run_lo = 0, run_hi = 0, pre_en = 0;
  logic [1:0] mode = 0, hi_src = 0;
  logic [7:0] cmp_lo = 0, cmp_hi = 0;
  logic irq_lo, irq_hi;
  logic [7:0] cnt_lo, cnt_hi;
  int n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  tmr_pair u_dut (.*);

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic restart();
    @(negedge clk);
    rst_n = 0; tick_lo = 0; tick_hi_ext = 0;
    @(negedge clk);
    rst_n = 1;
  endtask

  task automatic lo_ticks(input int n);
    tick_lo = 1;
    repeat (n) @(negedge clk);
    tick_lo = 0;
  endtask

  task automatic t_reset();
    rst_n = 0;
    @(negedge clk);
    chk("R1 cnt_lo", cnt_lo, 0); chk("R1 cnt_hi", cnt_hi, 0);
    chk("R1 irq_lo", irq_lo, 0); chk("R1 irq_hi", irq_hi, 0);
    rst_n = 1;
  endtask

  task automatic t_gate();
    restart();
    mode = 0; hi_src = 1; cmp_lo = 100; cmp_hi = 100;
    run_lo = 1; pre_en = 0; lo_ticks(5);
    chk("R2 pre_en low", cnt_lo, 0);
    run_lo = 0; pre_en = 1; lo_ticks(5);
    chk("R2 run low", cnt_lo, 0);
    run_lo = 1; repeat (4) @(negedge clk);
    chk("R2 tick low", cnt_lo, 0);
    lo_ticks(3);
    chk("R2 all on", cnt_lo, 3);
  endtask

  task automatic t_match8(input logic [1:0] m, input string req);
    restart();
    mode = m; hi_src = 1; cmp_lo = 4; cmp_hi = 100;
    run_lo = 1; run_hi = 1; pre_en = 1;
    lo_ticks(3);
    chk({req, " before match"}, cnt_lo, 3);
    chk({req, " no irq yet"}, irq_lo, 0);
    lo_ticks(1);
    chk({req, " cleared"}, cnt_lo, 0);
    chk({req, " irq_lo"}, irq_lo, 1);
    @(negedge clk);
    chk({req, " one cycle pulse"}, irq_lo, 0);
  endtask

  task automatic t_chain();
    restart();
    mode = 0; hi_src = 0; cmp_lo = 3; cmp_hi = 2;
    run_lo = 1; run_hi = 1; pre_en = 1; tick_hi_ext = 1;
    lo_ticks(2);
    chk("R4 ext ignored", cnt_hi, 0);
    lo_ticks(1);
    chk("R4 hi after one match", cnt_hi, 1);
    lo_ticks(3);
    chk("R4 hi cleared", cnt_hi, 0);
    chk("R4 irq_hi", irq_hi, 1);
    chk("R4 irq_lo same edge", irq_lo, 1);
  endtask

  task automatic t_ext();
    restart();
    mode = 0; hi_src = 2; cmp_lo = 2; cmp_hi = 200;
    run_lo = 1; run_hi = 1; pre_en = 1;
    tick_hi_ext = 1; repeat (5) @(negedge clk); tick_hi_ext = 0;
    chk("R5 hi ext count", cnt_hi, 5);
    lo_ticks(2);
    chk("R5 low match seen", irq_lo, 1);
    chk("R5 hi unchanged", cnt_hi, 5);
  endtask

  task automatic t_wide();
    restart();
    mode = 1; hi_src = 1; cmp_lo = 2; cmp_hi = 1;
    run_lo = 1; run_hi = 1; pre_en = 1; tick_hi_ext = 1;
    lo_ticks(2);
    chk("R7 low alone no clear", cnt_lo, 2);
    chk("R7 low alone no irq", irq_lo, 0);
    chk("R6 ext ignored", cnt_hi, 0);
    lo_ticks(253);
    chk("R6 low at 255", cnt_lo, 255);
    lo_ticks(1);
    chk("R6 wrap lo", cnt_lo, 0);
    chk("R6 carry hi", cnt_hi, 1);
    lo_ticks(2);
    chk("R7 lo cleared", cnt_lo, 0);
    chk("R7 hi cleared", cnt_hi, 0);
    chk("R7 irq_lo", irq_lo, 1);
    chk("R7 irq_hi", irq_hi, 1);
    tick_hi_ext = 0;
  endtask

  task automatic t_wrap();
    restart();
    mode = 0; hi_src = 1; cmp_lo = 0; cmp_hi = 100;
    run_lo = 1; pre_en = 1;
    lo_ticks(255);
    chk("R9 at 255", cnt_lo, 255);
    chk("R9 no irq", irq_lo, 0);
    lo_ticks(1);
    chk("R9 wrap match", irq_lo, 1);
    chk("R9 cleared", cnt_lo, 0);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_gate();
        t_match8(2'd0, "R3");
        t_chain();
        t_ext();
        t_wide();
        t_match8(2'd2, "R8 mode2");
        t_match8(2'd3, "R8 mode3");
        t_wrap();
      end
      begin
        repeat (20000) @(posedge clk);
        chk("watchdog", 1, 0);
      end
    join_any
    disable fork;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule